// File: doc/BRIEF.md
# Serial EEPROM Burst Read Sequencer

This block is a two-wire bus controller that fetches a burst of bytes from a serial EEPROM. A one-cycle start pulse captures a device select code, a word address, a byte count and an access mode. The block then drives the clock line and the open-drain data line until the burst completes. In random mode it first writes the word address without any data bytes, then turns the bus round with a repeated START and reads. In current-address mode it reads straight away from wherever the memory's own address counter points.

Each received byte is presented on a byte output together with a one-cycle valid strobe. The master acknowledges every byte except the final one. It NACKs the final byte and closes the bus with STOP. When STOP is complete, a one-cycle done pulse is raised. If the slave does not acknowledge a select or address byte, the burst is abandoned with STOP and an error flag is raised. The bus rate comes from a runtime divider input: every clock period is split into four equal quarters of that many system clocks.

Top module: `eeprom_burst_reader`

## Requirements
- R1: Out of reset, `scl_o` is 1, `sda_oe_o` is 0 (line released), and `rvalid_o`, `done_o` and `nack_err_o` are all 0.
- R2: With `random_i`=1, the bus sequence is as follows. START. A select byte (bits 7:4 = 1010, bits 3:1 = `dev_i`, bit 0 = 0). The high word-address byte, then the low word-address byte. A repeated START with no STOP before it. A select byte with bit 0 = 1. The block waits for that byte's acknowledge before any data bit is clocked.
- R3: With `random_i`=0, the only START is followed directly by the select byte with bit 0 = 1. No address byte is sent, and the data continues from the memory's internal address counter.
- R4: A count of N (N ≥ 1) produces exactly N one-cycle `rvalid_o` pulses. Each byte is assembled MSB first (the first bit on the wire is bit 7), and bytes appear in bus order.
- R5: The master drives ACK (SDA low) after every received byte except the last. After the last byte it leaves SDA high (NACK) and then issues STOP.
- R6: If a select or address byte is not acknowledged, the block issues STOP and produces no `rvalid_o` pulse. It sets `nack_err_o` in the same cycle that `done_o` pulses.
- R7: `done_o` is high for exactly one clock, just after the STOP condition has released SDA while SCL is high. In that cycle `scl_o`=1 and `sda_oe_o`=0.
- R8: During address, data and acknowledge bits, SDA changes only while SCL is low. SDA changes with SCL high only to form START or STOP. The slave's SDA is sampled at the middle of the SCL high time.
- R9: While a burst runs, successive SCL rising edges are exactly 4×`div_i` system clocks apart. A `div_i` below 2 behaves as 2.
- R10: `start_i` has no effect while a burst is in progress. It also has no effect when `count_i` is 0; in that case the bus stays idle and no `done_o` follows.
- R11: `nack_err_o` keeps its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a burst |
| random_i | input | 1 | 1: address phase then read; 0: read from current address |
| dev_i | input | 3 | Device select bits placed in the select byte |
| waddr_i | input | 16 | Word address for random mode |
| count_i | input | 8 | Number of bytes to read |
| div_i | input | 12 | System clocks per quarter of an SCL period |
| sda_i | input | 1 | Sampled level of the data line |
| scl_o | output | 1 | Clock line level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| rdata_o | output | 8 | Last received byte |
| rvalid_o | output | 1 | One-cycle strobe marking a new `rdata_o` |
| done_o | output | 1 | One-cycle pulse after STOP |
| nack_err_o | output | 1 | Last burst aborted on a missing acknowledge |

## Verification
Some properties are checked on every cycle. SDA holds steady through the high half of each address, data and acknowledge bit. Quarter ticks never come back to back. Valid and done strobes last one clock, and done always finds the bus idle. The error flag rises only together with done, and no data strobe appears after an abort. Other behaviour can only be shown by the bench's scenarios against a modelled memory. These are the byte ordering and the wrap of the memory counter, the START/STOP count of each mode, and the ACK/NACK pattern on the final byte. They also cover the exact SCL period for several divider values, recovery after an aborted burst, and the ignored start requests.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

   localparam int          BYTE_W     = 8;
   localparam int          DEVSEL_W   = 3;
   localparam logic [3:0]  SEL_PREFIX = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_TX,
      ST_RX,
      ST_STOP
   } rd_state_e;

   typedef enum logic [1:0] {
      SG_SELW,
      SG_AHI,
      SG_ALO,
      SG_SELR
   } rd_seg_e;

   function automatic logic [BYTE_W-1:0] make_select(input logic [DEVSEL_W-1:0] dev,
                                                     input logic rd);
      return {SEL_PREFIX, dev, rd};
   endfunction

endpackage

// File: rtl/rdseq_qtick.sv
module rdseq_qtick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
   localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] eff;

   if (DIV_W < 2) begin : g_chk_w
      $error("rdseq_qtick: DIV_W must be at least 2");
   end

   assign eff  = (div < MIN_DIV) ? MIN_DIV : div;
   assign tick = run && (cnt >= eff - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + ONE;
   end

   // R9: a quarter lasts at least two system clocks
   assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rdseq_shreg.sv
module rdseq_shreg #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_tx,
   input  logic         shift_rx,
   input  logic         rx_bit,
   output logic         tx_bit,
   output logic [W-1:0] rx_val
);

   logic [W-1:0] tx_r;
   logic [W-1:0] tx_nx;
   logic [W-1:0] rx_nx;

   if (W < 2) begin : g_chk_w
      $error("rdseq_shreg: W must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb
      assign tx_bit = tx_r[W-1];
      assign tx_nx  = {tx_r[W-2:0], 1'b0};
      assign rx_nx  = {rx_val[W-2:0], rx_bit};
   end else begin : g_lsb
      assign tx_bit = tx_r[0];
      assign tx_nx  = {1'b0, tx_r[W-1:1]};
      assign rx_nx  = {rx_bit, rx_val[W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_r   <= '0;
         rx_val <= '0;
      end else begin
         if (load)          tx_r <= load_val;
         else if (shift_tx) tx_r <= tx_nx;
         if (shift_rx)      rx_val <= rx_nx;
      end
   end

   // R4: a byte is never loaded and shifted in the same cycle
   assert_load_shift_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift_tx));

endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
   import rdseq_pkg::*;
#(
   parameter int DIV_W      = 12,
   parameter int CNT_W      = 8,
   parameter int ADDR_BYTES = 2,
   localparam int AW        = 8 * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              random_i,
   input  logic [2:0]        dev_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              sda_i,
   output logic              scl_o,
   output logic              sda_oe_o,
   output logic [7:0]        rdata_o,
   output logic              rvalid_o,
   output logic              done_o,
   output logic              nack_err_o
);

   localparam logic [3:0]       LAST_BIT  = 4'd8;
   localparam logic [3:0]       DATA_LAST = 4'd7;
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
   localparam rd_seg_e          FIRST_ADR = (ADDR_BYTES == 2) ? SG_AHI : SG_ALO;

   if (ADDR_BYTES < 1 || ADDR_BYTES > 2) begin : g_chk_ab
      $error("eeprom_burst_reader: ADDR_BYTES must be 1 or 2");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("eeprom_burst_reader: CNT_W must be at least 1");
   end

   rd_state_e            st;
   rd_seg_e              seg;
   rd_seg_e              nxt_seg;
   logic [1:0]           q;
   logic [3:0]           bitn;
   logic [CNT_W-1:0]     rem;
   logic [DEVSEL_W-1:0]  dev_q;
   logic [AW-1:0]        addr_q;
   logic                 ack_bad;
   logic                 abort_q;

   logic                 tick;
   logic                 slot_end;
   logic                 sample;
   logic                 last;
   logic                 load_en;
   logic [BYTE_W-1:0]    load_val;
   logic [BYTE_W-1:0]    hi_byte;
   logic                 tx_bit;
   logic [BYTE_W-1:0]    rx_val;
   logic                 scl_nx;
   logic                 oe_nx;

   rdseq_qtick #(.DIV_W(DIV_W)) u_qtick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st != ST_IDLE),
      .div   (div_i),
      .tick  (tick)
   );

   assign slot_end = tick && (q == 2'd3);
   assign sample   = tick && (q == 2'd2);
   assign last     = (rem == CNT_ONE);

   if (ADDR_BYTES == 2) begin : g_two_adr
      assign hi_byte = addr_q[AW-1 -: 8];
   end else begin : g_one_adr
      assign hi_byte = 8'h00;
   end

   // byte that the next transmit slot will carry
   always_comb begin
      if (st == ST_START)       nxt_seg = seg;
      else if (seg == SG_SELW)  nxt_seg = FIRST_ADR;
      else                      nxt_seg = SG_ALO;
      unique case (nxt_seg)
         SG_SELW: load_val = make_select(dev_q, 1'b0);
         SG_AHI:  load_val = hi_byte;
         SG_ALO:  load_val = addr_q[7:0];
         default: load_val = make_select(dev_q, 1'b1);
      endcase
   end

   assign load_en = slot_end && ((st == ST_START) ||
                    (st == ST_TX && bitn == LAST_BIT && !ack_bad &&
                     (seg == SG_SELW || seg == SG_AHI)));

   rdseq_shreg #(.W(BYTE_W), .MSB_FIRST(1'b1)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_en),
      .load_val (load_val),
      .shift_tx (slot_end && st == ST_TX && bitn != LAST_BIT),
      .shift_rx (sample && st == ST_RX && bitn != LAST_BIT),
      .rx_bit   (sda_i),
      .tx_bit   (tx_bit),
      .rx_val   (rx_val)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         seg        <= SG_SELW;
         q          <= '0;
         bitn       <= '0;
         rem        <= '0;
         dev_q      <= '0;
         addr_q     <= '0;
         ack_bad    <= 1'b0;
         abort_q    <= 1'b0;
         rdata_o    <= '0;
         rvalid_o   <= 1'b0;
         done_o     <= 1'b0;
         nack_err_o <= 1'b0;
      end else begin
         rvalid_o <= 1'b0;
         done_o   <= 1'b0;
         if (sample && st == ST_TX && bitn == LAST_BIT) ack_bad <= sda_i;
         if (st == ST_IDLE) begin
            if (start_i && count_i != '0) begin
               st         <= ST_START;
               seg        <= random_i ? SG_SELW : SG_SELR;
               q          <= '0;
               bitn       <= '0;
               rem        <= count_i;
               dev_q      <= dev_i;
               addr_q     <= waddr_i;
               abort_q    <= 1'b0;
               nack_err_o <= 1'b0;
            end
         end else if (tick) begin
            q <= q + 2'd1;
            if (slot_end) begin
               unique case (st)
                  ST_START: begin
                     st   <= ST_TX;
                     bitn <= '0;
                  end
                  ST_TX: begin
                     if (bitn != LAST_BIT) begin
                        bitn <= bitn + 4'd1;
                     end else if (ack_bad) begin
                        abort_q <= 1'b1;
                        st      <= ST_STOP;
                     end else begin
                        bitn <= '0;
                        unique case (seg)
                           SG_SELR: st <= ST_RX;
                           SG_ALO: begin
                              seg <= SG_SELR;
                              st  <= ST_START;
                           end
                           default: seg <= nxt_seg;
                        endcase
                     end
                  end
                  ST_RX: begin
                     if (bitn != LAST_BIT) begin
                        if (bitn == DATA_LAST) begin
                           rdata_o  <= rx_val;
                           rvalid_o <= 1'b1;
                        end
                        bitn <= bitn + 4'd1;
                     end else if (last) begin
                        st <= ST_STOP;
                     end else begin
                        rem  <= rem - CNT_ONE;
                        bitn <= '0;
                     end
                  end
                  ST_STOP: begin
                     st         <= ST_IDLE;
                     done_o     <= 1'b1;
                     nack_err_o <= abort_q;
                  end
                  default: st <= ST_IDLE;
               endcase
            end
         end
      end
   end

   // line levels: SCL high in the second half of each slot; SDA held in the
   // first quarter and updated in the second, both while SCL is low
   always_comb begin
      scl_nx = q[1];
      oe_nx  = sda_oe_o;
      unique case (st)
         ST_IDLE: begin
            scl_nx = 1'b1;
            oe_nx  = 1'b0;
         end
         ST_START: if (q != 2'd0) oe_nx = (q == 2'd3);
         ST_TX:    if (q != 2'd0) oe_nx = (bitn == LAST_BIT) ? 1'b0 : !tx_bit;
         ST_RX:    if (q != 2'd0) oe_nx = (bitn == LAST_BIT) ? !last : 1'b0;
         ST_STOP:  if (q != 2'd0) oe_nx = (q != 2'd3);
         default: begin
            scl_nx = 1'b1;
            oe_nx  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_o    <= 1'b1;
         sda_oe_o <= 1'b0;
      end else begin
         scl_o    <= scl_nx;
         sda_oe_o <= oe_nx;
      end
   end

   // R8: SDA steady while SCL is high inside a bit slot
   assert_sda_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && ($past(st) == ST_TX || $past(st) == ST_RX))
      |-> $stable(sda_oe_o));

   // R4: data strobe lasts one clock
   assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |=> !rvalid_o);

   // R7: done is a single clock with the bus idle
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (scl_o && !sda_oe_o));

   // R6: error rises only with done, and no data follows an abort
   assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack_err_o) |-> done_o);
   assert_no_data_after_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> !rvalid_o);

endmodule

// File: tb/test_eeprom_burst_reader.sv
module test_eeprom_burst_reader;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_AW     = 13;
   localparam logic [2:0] SDEV = 3'b101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        random_i = 1'b0;
   logic [2:0]  dev_i = '0;
   logic [15:0] waddr_i = '0;
   logic [7:0]  count_i = '0;
   logic [11:0] div_i = 12'd2;
   logic        scl_o, sda_oe_o, rvalid_o, done_o, nack_err_o;
   logic [7:0]  rdata_o;
   logic        s_drv = 1'b0;
   wire         sda = !(sda_oe_o || s_drv);

   always #(CLK_PERIOD/2) clk = !clk;

   eeprom_burst_reader i_eeprom_burst_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .random_i(random_i),
      .dev_i(dev_i), .waddr_i(waddr_i), .count_i(count_i), .div_i(div_i),
      .sda_i(sda), .scl_o(scl_o), .sda_oe_o(sda_oe_o), .rdata_o(rdata_o),
      .rvalid_o(rvalid_o), .done_o(done_o), .nack_err_o(nack_err_o)
   );

   function automatic logic [7:0] mem_at(input logic [MEM_AW-1:0] a);
      return 8'(a[7:0] * 8'd13) ^ {3'b000, a[12:8]} ^ 8'hA5;
   endfunction

   // ---------------- memory slave model ----------------
   int inj_ph = 0;
   int s_starts = 0, s_stops = 0, s_wsel = 0, s_rsel = 0, s_acks = 0, s_nacks = 0;
   int ph = 0, bc = 0;
   logic [7:0] rx = '0, tx = '0, ahi = '0;
   logic [MEM_AW-1:0] ptr = '0;
   logic sc_p = 1'b1, sd_p = 1'b1, mack = 1'b0;

   always @(posedge clk) begin
      logic sc, sd, ok;
      sc = scl_o;
      sd = sda;
      if (rst_n) begin
         if (sc && sc_p && sd_p && !sd) begin
            ph = 1; bc = 0; s_starts++; s_drv <= 1'b0;
         end else if (sc && sc_p && !sd_p && sd) begin
            ph = 0; s_stops++; s_drv <= 1'b0;
         end else if (sc && !sc_p) begin
            if (ph >= 1 && ph <= 3) begin
               if (bc < 8) rx = {rx[6:0], sd};
               bc++;
            end else if (ph == 5) begin
               if (bc == 8) begin
                  mack = !sd;
                  if (sd) s_nacks++; else s_acks++;
               end
               bc++;
            end
         end else if (!sc && sc_p) begin
            if (ph >= 1 && ph <= 3) begin
               if (bc == 8) begin
                  ok = (ph != 1) || (rx[7:1] == {4'b1010, SDEV});
                  if (inj_ph == ph) ok = 1'b0;
                  if (ok) s_drv <= 1'b1; else ph = 0;
               end else if (bc == 9) begin
                  s_drv <= 1'b0;
                  bc = 0;
                  case (ph)
                     1: if (rx[0]) begin
                           s_rsel++; tx = mem_at(ptr); ptr = ptr + 1'b1;
                           ph = 5; s_drv <= !tx[7];
                        end else begin
                           s_wsel++; ph = 2;
                        end
                     2: begin ahi = rx; ph = 3; end
                     default: begin ptr = MEM_AW'({ahi, rx}); ph = 4; end
                  endcase
               end
            end else if (ph == 5) begin
               if (bc < 8) s_drv <= !tx[7-bc];
               else if (bc == 8) s_drv <= 1'b0;
               else if (mack) begin
                  tx = mem_at(ptr); ptr = ptr + 1'b1; bc = 0; s_drv <= !tx[7];
               end else begin
                  ph = 0; s_drv <= 1'b0;
               end
            end
         end
      end
      sc_p = sc;
      sd_p = sd;
   end

   // ---------------- SCL period tracker ----------------
   int burst_id = 0, in_burst = 0, exp_period = 8, period_bad = 0;
   int cyc = 0, rise_prev = 0, seen_id = -1;
   logic scl_pb = 1'b1;
   always @(negedge clk) begin
      cyc++;
      if (scl_o && !scl_pb) begin
         if (in_burst != 0 && seen_id == burst_id && (cyc - rise_prev) != exp_period)
            period_bad++;
         rise_prev = cyc;
         seen_id = burst_id;
      end
      scl_pb = scl_o;
   end

   // ---------------- scoreboard monitor ----------------
   logic [7:0] expq[$];
   int mon_checks = 0, mon_errs = 0;
   always @(negedge clk) begin
      if (rst_n && rvalid_o) begin
         mon_checks++;
         if (expq.size() == 0) begin
            mon_errs++;
            $display("FAIL R4/R6: unexpected strobe actual=%0d expected=none", rdata_o);
         end else begin
            logic [7:0] e;
            e = expq.pop_front();
            if (rdata_o !== e) begin
               mon_errs++;
               $display("FAIL R4: byte actual=%0d expected=%0d", rdata_o, e);
            end
         end
      end
   end

   // ---------------- driver ----------------
   int checks = 0, errs = 0;
   logic [MEM_AW-1:0] exp_ptr = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_burst(input bit rnd, input logic [2:0] dev, input logic [15:0] adr,
                            input int n, input int dv, input bit exp_err, input int inj,
                            input bit poke);
      int st0, sp0, ws0, rs0, ak0, nk0, pb0, wait_n;
      logic [MEM_AW-1:0] base;
      st0 = s_starts; sp0 = s_stops; ws0 = s_wsel; rs0 = s_rsel;
      ak0 = s_acks; nk0 = s_nacks; pb0 = period_bad;
      base = rnd ? MEM_AW'(adr) : exp_ptr;
      if (!exp_err)
         for (int i = 0; i < n; i++) expq.push_back(mem_at(base + MEM_AW'(i)));
      @(negedge clk);
      inj_ph = inj;
      burst_id++;
      exp_period = 4 * ((dv < 2) ? 2 : dv);
      in_burst = 1;
      random_i = rnd; dev_i = dev; waddr_i = adr; count_i = 8'(n); div_i = 12'(dv);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         repeat (40) @(negedge clk);
         random_i = !rnd; waddr_i = 16'h0500; count_i = 8'd5; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait_n = 0;
      while (!done_o && wait_n < 20000) begin
         @(negedge clk);
         wait_n++;
      end
      chk(done_o === 1'b1, "R7 done reached", int'(done_o), 1);
      chk(scl_o === 1'b1 && sda_oe_o === 1'b0, "R7 bus idle at done",
          int'({scl_o, sda_oe_o}), 2);
      chk(nack_err_o === exp_err, "R6/R11 error flag", int'(nack_err_o), int'(exp_err));
      @(negedge clk);
      chk(done_o === 1'b0, "R7 done one clock", int'(done_o), 0);
      in_burst = 0;
      inj_ph = 0;
      chk(expq.size() == 0, "R4 strobe count", expq.size(), 0);
      expq.delete();
      chk(s_stops - sp0 == 1, "R5 one STOP", s_stops - sp0, 1);
      chk(period_bad == pb0, "R9 SCL period", period_bad - pb0, 0);
      if (!exp_err) begin
         chk(s_starts - st0 == (rnd ? 2 : 1), rnd ? "R2/R8 START count" : "R3/R8 START count",
             s_starts - st0, rnd ? 2 : 1);
         chk(s_wsel - ws0 == (rnd ? 1 : 0), rnd ? "R2 write select" : "R3 no address phase",
             s_wsel - ws0, rnd ? 1 : 0);
         chk(s_rsel - rs0 == 1, "R2 read select", s_rsel - rs0, 1);
         chk(s_acks - ak0 == n - 1, "R5 master ACKs", s_acks - ak0, n - 1);
         chk(s_nacks - nk0 == 1, "R5 final NACK", s_nacks - nk0, 1);
         exp_ptr = base + MEM_AW'(n);
      end else begin
         chk(s_starts - st0 == 1, "R6 no repeated START", s_starts - st0, 1);
         chk(s_rsel - rs0 == 0, "R6 no read select", s_rsel - rs0, 0);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs + mon_errs + 1, checks + mon_checks + 1);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk(scl_o === 1'b1, "R1 scl reset", int'(scl_o), 1);
      chk(sda_oe_o === 1'b0, "R1 sda reset", int'(sda_oe_o), 0);
      chk({rvalid_o, done_o, nack_err_o} === 3'b000, "R1 flags reset",
          int'({rvalid_o, done_o, nack_err_o}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_burst(1'b1, SDEV, 16'h0123, 3, 3, 1'b0, 0, 1'b0);   // R2 random read
      run_burst(1'b0, SDEV, 16'h0000, 2, 2, 1'b0, 0, 1'b0);   // R3 current address
      run_burst(1'b1, SDEV, 16'h1FFE, 4, 4, 1'b0, 0, 1'b0);   // R4 across wrap
      run_burst(1'b1, SDEV, 16'h0040, 1, 0, 1'b0, 0, 1'b0);   // R5 single byte, R9 clamp
      run_burst(1'b1, 3'b010, 16'h0077, 2, 2, 1'b1, 0, 1'b0); // R6 select NACK
      run_burst(1'b1, SDEV, 16'h0200, 2, 2, 1'b1, 3, 1'b0);   // R6 address NACK
      run_burst(1'b0, SDEV, 16'h0000, 3, 2, 1'b0, 0, 1'b1);   // R10 busy start, R11 clear

      // R10: zero count is ignored
      begin
         int busy_seen;
         busy_seen = 0;
         @(negedge clk);
         count_i = 8'd0; random_i = 1'b1; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!scl_o || sda_oe_o || done_o) busy_seen++;
         end
         chk(busy_seen == 0, "R10 zero count ignored", busy_seen, 0);
         chk(nack_err_o === 1'b0, "R11 flag unchanged", int'(nack_err_o), 0);
      end

      $display("Result: errors=%0d of %0d checks", errs + mon_errs, checks + mon_checks);
      $finish;
   end

endmodule